// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a two-channel serial audio stream made of a bit clock, a channel-select (LR) clock and one data line, and rebuilds the signed 24-bit left and right samples of each frame. All three pins are brought into an oversampled system clock domain. The block finds the bit-clock rising edges itself and samples the data and LR lines at those edges. A 3-bit format input picks one of five framings: right-justified at 16, 20 or 24 bits, 24-bit left-justified, and I2S. One shift path and one bit collector serve all five.

A four-state machine tracks the frame. ST_HUNT waits for the first bit-clock edge after reset or after a format change, and moves to ST_WAIT on that edge. ST_WAIT waits for an LR change into the left-channel level, and moves to ST_LEFT on it. ST_LEFT moves to ST_RIGHT on the next LR change and holds the finished left word. ST_RIGHT moves back to ST_LEFT on the next LR change. On that move it publishes both words and pulses the valid strobe. A format change, or a reserved format code, sends any state to ST_HUNT. Samples shorter than 24 bits come out left-aligned, with zeros below them.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is held, and after it is released, valid_o is 0 and left_o and right_o are 0 until the first strobe.
- R2: Data and LR are sampled at the rising edge of the bit clock, and the first bit of a word is its most significant bit. A level change on the data line between two rising edges has no effect.
- R3: In format 011 (I2S), LR low is the left channel. The MSB comes on the second bit clock after the LR change. With 32 bit clocks per half frame, the first 24 bits are the sample and the remaining bits are ignored.
- R4: In format 011 with 16 bit clocks per half frame, the word is 16 bits long and its LSB is the first bit after the next LR change. It is output as the top 16 bits, with 8 zero LSBs.
- R5: In format 010 (left-justified), LR high is the left channel and the MSB is the first bit after the LR change. Bits past the 24th are ignored. A half frame shorter than 24 bits gives a word with zero LSBs.
- R6: In formats 000, 001 and 100 (right-justified 16, 20 and 24 bits), LR high is the left channel. The word is the last 16, 20 or 24 bits before the LR change and is left-aligned with zero LSBs. Earlier bits are ignored.
- R7: valid_o is high for exactly one system clock. It rises 3 system clocks after the bit-clock rising edge that shows the right-to-left LR change. left_o and right_o then hold the two words of that frame.
- R8: After reset or any change of fmt_i, no strobe is produced until a complete left half and right half have been received. A partial frame at the start of a stream is never reported.
- R9: Format codes 101, 110 and 111 produce no strobe.
- R10: left_o and right_o change only in the cycle where valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| lrclk_i | input | 1 | Channel-select clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first, two's complement |
| fmt_i | input | 3 | Framing select (000, 001, 010, 011, 100) |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a complete frame |

## Verification
Each bit-clock rise is driven four system clocks away from the data and LR changes. Three system clocks later, the sample becomes the strobe: two synchroniser flops, then the edge-detect flop that also registers the frame outputs. The bench records the system-clock count at every rise that opens a left half. It samples the outputs on falling system-clock edges and requires each strobe to land exactly three counts later. Frame words are checked against values that the bench computes from its own stimulus. Hold behaviour and strobe counts are checked per sweep, after the stream has settled for several cycles.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int unsigned WORD_W = 24;
    localparam int unsigned CNT_W  = $clog2(WORD_W + 1);
    localparam int unsigned W16    = 16;
    localparam int unsigned W20    = 20;
    localparam int unsigned FMT_W  = 3;

    typedef enum logic [FMT_W-1:0] {
        FMT_RJ16 = 3'b000,
        FMT_RJ20 = 3'b001,
        FMT_LJ24 = 3'b010,
        FMT_I2S  = 3'b011,
        FMT_RJ24 = 3'b100
    } fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_WAIT,
        ST_LEFT,
        ST_RIGHT
    } rx_state_e;

    function automatic logic fmt_known(input logic [FMT_W-1:0] f);
        return f <= FMT_RJ24;
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync
    import aud_rx_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_pin,
    input  logic lr_pin,
    input  logic data_pin,
    output logic bit_ev,
    output logic lr_bit,
    output logic data_bit,
    output logic lr_edge
);

    localparam int unsigned NLANES = 3;

    logic [NLANES-1:0] pin_v;
    logic [NLANES-1:0] sync_v;
    logic              bclk_d;
    logic              lr_last;

    assign pin_v = {data_pin, lr_pin, bclk_pin};

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [STAGES-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= {q[STAGES-2:0], pin_v[g]};
            end
        end
        assign sync_v[g] = q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d  <= 1'b0;
            lr_last <= 1'b0;
        end else begin
            bclk_d <= sync_v[0];
            if (bit_ev) begin
                lr_last <= sync_v[1];
            end
        end
    end

    assign bit_ev   = sync_v[0] & ~bclk_d;
    assign lr_bit   = sync_v[1];
    assign data_bit = sync_v[2];
    assign lr_edge  = bit_ev & (sync_v[1] != lr_last);

endmodule

// File: rtl/aud_rx_word.sv
module aud_rx_word
    import aud_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_ev,
    input  logic              lr_edge,
    input  logic              data_bit,
    input  logic [FMT_W-1:0]  fmt,
    output logic [WORD_W-1:0] fin,
    output logic [CNT_W-1:0]  fill
);

    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] col_q;
    logic [CNT_W-1:0]  ncol_q;
    logic [CNT_W-1:0]  pos;
    logic              room;
    logic [WORD_W-1:0] i2s_word;

    assign pos  = CNT_W'(WORD_W - 1) - ncol_q;
    assign room = ncol_q < CNT_W'(WORD_W);
    assign fill = ncol_q;

    always_comb begin
        i2s_word = col_q;
        if (room) begin
            i2s_word[pos] = data_bit;
        end
    end

    always_comb begin
        unique case (fmt)
            FMT_RJ16: fin = {sh_q[W16-1:0], {(WORD_W - W16){1'b0}}};
            FMT_RJ20: fin = {sh_q[W20-1:0], {(WORD_W - W20){1'b0}}};
            FMT_RJ24: fin = sh_q;
            FMT_LJ24: fin = col_q;
            FMT_I2S:  fin = i2s_word;
            default:  fin = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh_q   <= '0;
            col_q  <= '0;
            ncol_q <= '0;
        end else if (bit_ev) begin
            sh_q <= {sh_q[WORD_W-2:0], data_bit};
            if (lr_edge) begin
                if (fmt == FMT_LJ24) begin
                    col_q  <= {data_bit, {(WORD_W - 1){1'b0}}};
                    ncol_q <= CNT_W'(1);
                end else begin
                    col_q  <= '0;
                    ncol_q <= '0;
                end
            end else if (room) begin
                col_q[pos] <= data_bit;
                ncol_q     <= ncol_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/aud_rx_fsm.sv
module aud_rx_fsm
    import aud_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_ev,
    input  logic              lr_edge,
    input  logic              lr_bit,
    input  logic [FMT_W-1:0]  fmt,
    input  logic              fmt_chg,
    input  logic [WORD_W-1:0] fin,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o,
    output rx_state_e         state
);

    rx_state_e         state_q;
    rx_state_e         state_d;
    logic              abort;
    logic              to_left;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] left_q;
    logic [WORD_W-1:0] right_q;
    logic              valid_q;

    assign abort   = fmt_chg | ~fmt_known(fmt);
    assign to_left = (fmt == FMT_I2S) ? ~lr_bit : lr_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT:  if (bit_ev)              state_d = ST_WAIT;
                ST_WAIT:  if (lr_edge && to_left)  state_d = ST_LEFT;
                ST_LEFT:  if (lr_edge)             state_d = ST_RIGHT;
                ST_RIGHT: if (lr_edge)             state_d = ST_LEFT;
                default:                           state_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            left_q  <= '0;
            right_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (!abort && lr_edge) begin
                if (state_q == ST_LEFT) begin
                    hold_q <= fin;
                end else if (state_q == ST_RIGHT) begin
                    left_q  <= hold_q;
                    right_q <= fin;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign left_o  = left_q;
    assign right_o = right_q;
    assign valid_o = valid_q;
    assign state   = state_q;

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              lrclk_i,
    input  logic              sdata_i,
    input  logic [2:0]        fmt_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);

    logic              bit_ev;
    logic              lr_bit;
    logic              data_bit;
    logic              lr_edge;
    logic [FMT_W-1:0]  fmt_q;
    logic              fmt_chg;
    logic [WORD_W-1:0] fin;
    logic [CNT_W-1:0]  fill;
    rx_state_e         st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= FMT_I2S;
        end else begin
            fmt_q <= fmt_i;
        end
    end

    assign fmt_chg = fmt_i != fmt_q;

    aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_pin (bclk_i),
        .lr_pin   (lrclk_i),
        .data_pin (sdata_i),
        .bit_ev   (bit_ev),
        .lr_bit   (lr_bit),
        .data_bit (data_bit),
        .lr_edge  (lr_edge)
    );

    aud_rx_word u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fmt_chg),
        .bit_ev   (bit_ev),
        .lr_edge  (lr_edge),
        .data_bit (data_bit),
        .fmt      (fmt_q),
        .fin      (fin),
        .fill     (fill)
    );

    aud_rx_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_ev   (bit_ev),
        .lr_edge  (lr_edge),
        .lr_bit   (lr_bit),
        .fmt      (fmt_q),
        .fmt_chg  (fmt_chg),
        .fin      (fin),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o),
        .state    (st)
    );

endmodule

// File: rtl/aud_rx_checker.sv
module aud_rx_checker
    import aud_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_o,
    input logic [WORD_W-1:0] left_o,
    input logic [WORD_W-1:0] right_o,
    input rx_state_e         st,
    input logic              bit_ev,
    input logic              lr_edge,
    input logic [FMT_W-1:0]  fmt_q,
    input logic              fmt_chg,
    input logic [CNT_W-1:0]  fill
);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r7_after_right_edge: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(bit_ev && lr_edge && st == ST_RIGHT));

    a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(fmt_q) <= 3'd4));

    a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    a_r8_change_rehunts: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_chg |=> st == ST_HUNT);

    a_r5_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(WORD_W));

endmodule

bind aud_serial_rx aud_rx_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_o (valid_o),
    .left_o  (left_o),
    .right_o (right_o),
    .st      (st),
    .bit_ev  (bit_ev),
    .lr_edge (lr_edge),
    .fmt_q   (fmt_q),
    .fmt_chg (fmt_chg),
    .fill    (fill)
);

// File: tb/tb_aud_serial_rx.sv
module tb_aud_serial_rx;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bclk;
    logic        lrclk;
    logic        sdata;
    logic [2:0]  fmt;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;

    always #10 clk = ~clk;

    aud_serial_rx dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (bclk),
        .lrclk_i (lrclk),
        .sdata_i (sdata),
        .fmt_i   (fmt),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    longint      cyc = 0;
    longint      rise_cyc = 0;
    logic [23:0] got_l [8];
    logic [23:0] got_r [8];
    int          got_n = 0;
    int          lat_bad = 0;
    int          hold_bad = 0;
    logic [23:0] last_l = '0;
    logic [23:0] last_r = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (valid_o) begin
                if (got_n < 8) begin
                    got_l[got_n] = left_o;
                    got_r[got_n] = right_o;
                end
                got_n = got_n + 1;
                if (cyc != rise_cyc + 3) lat_bad = lat_bad + 1;
            end else if (left_o !== last_l || right_o !== last_r) begin
                hold_bad = hold_bad + 1;
            end
            last_l = left_o;
            last_r = right_o;
        end
    end

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [23:0] frame_word(input int s, input int k, input bit ch);
        logic [31:0] h;
        if (k == 0) return ch ? 24'h7FFFFF : 24'h800000;
        h = 32'(s * 131 + k * 17 + (ch ? 7 : 0) + 1) * 32'h2545F491;
        return h[27:4];
    endfunction

    function automatic int word_len(input logic [2:0] f, input int h);
        case (f)
            3'b000:  return 16;
            3'b001:  return 20;
            3'b100:  return 24;
            default: return (h < 24) ? h : 24;
        endcase
    endfunction

    function automatic logic [23:0] trim(input logic [23:0] w, input int len);
        logic [23:0] m = '0;
        for (int b = 0; b < 24; b++) if (b >= 24 - len) m[b] = 1'b1;
        return w & m;
    endfunction

    function automatic logic stream_bit(input logic [2:0] f, input int h, input int i,
                                        input logic [23:0] w, input logic [23:0] pw);
        int          o;
        logic [23:0] src;
        src = w;
        if (f == 3'b011) begin
            if (i == 0) begin
                o   = h - 1;
                src = pw;
            end else begin
                o = i - 1;
            end
        end else if (f == 3'b010) begin
            o = i;
        end else begin
            o = i - (h - word_len(f, h));
        end
        if (o < 0 || o >= 24) return (i % 3) == 1;
        return src[23 - o];
    endfunction

    task automatic send_bit(input logic lr, input logic d, input bit mark);
        lrclk = lr;
        sdata = d;
        bclk  = 1'b0;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        if (mark) rise_cyc = cyc;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_sweep(input string tag, input logic [2:0] f, input int h,
                             input int s, input bit expect_frames);
        localparam int NF = 4;
        logic        lr_left;
        logic [23:0] lw;
        logic [23:0] rw;
        logic [23:0] pw;
        int          len;
        fmt = 3'b111;
        repeat (6) @(negedge clk);
        got_n    = 0;
        lat_bad  = 0;
        hold_bad = 0;
        fmt = f;
        repeat (4) @(negedge clk);
        lr_left = (f == 3'b011) ? 1'b0 : 1'b1;
        pw = '0;
        send_bit(~lr_left, 1'b1, 1'b0);
        send_bit(~lr_left, 1'b0, 1'b0);
        for (int k = 0; k < NF; k++) begin
            lw = frame_word(s, k, 1'b0);
            rw = frame_word(s, k, 1'b1);
            for (int i = 0; i < h; i++) send_bit(lr_left, stream_bit(f, h, i, lw, pw), i == 0);
            for (int i = 0; i < h; i++) send_bit(~lr_left, stream_bit(f, h, i, rw, lw), 1'b0);
            pw = rw;
        end
        send_bit(lr_left, stream_bit(f, h, 0, '0, pw), 1'b1);
        repeat (6) @(negedge clk);
        if (!expect_frames) begin
            check_int({tag, " R9 reserved code strobe count"}, got_n, 0);
        end else begin
            len = word_len(f, h);
            check_int({tag, " R8 strobes equal whole frames"}, got_n, NF);
            for (int k = 0; k < NF; k++) begin
                check({tag, " R2 left word"}, got_l[k], trim(frame_word(s, k, 1'b0), len));
                check({tag, " R2 right word"}, got_r[k], trim(frame_word(s, k, 1'b1), len));
            end
            check_int({tag, " R7 strobe latency misses"}, lat_bad, 0);
            check_int({tag, " R10 outputs moved without strobe"}, hold_bad, 0);
        end
    endtask

    initial begin
        #3000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bclk  = 1'b0;
        lrclk = 1'b0;
        sdata = 1'b0;
        fmt   = 3'b011;
        repeat (5) @(negedge clk);
        check("R1 valid in reset", {23'd0, valid_o}, 24'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 left after reset", left_o, 24'd0);
        check("R1 right after reset", right_o, 24'd0);
        check("R1 valid after reset", {23'd0, valid_o}, 24'd0);

        run_sweep("R3 i2s 64fs",   3'b011, 32, 1, 1'b1);
        run_sweep("R4 i2s 32fs",   3'b011, 16, 2, 1'b1);
        run_sweep("R5 lj 64fs",    3'b010, 32, 3, 1'b1);
        run_sweep("R5 lj 48fs",    3'b010, 24, 4, 1'b1);
        run_sweep("R5 lj short",   3'b010, 20, 5, 1'b1);
        run_sweep("R6 rj16 32fs",  3'b000, 16, 6, 1'b1);
        run_sweep("R6 rj16 64fs",  3'b000, 32, 7, 1'b1);
        run_sweep("R6 rj20 40fs",  3'b001, 20, 8, 1'b1);
        run_sweep("R6 rj20 64fs",  3'b001, 32, 9, 1'b1);
        run_sweep("R6 rj24 48fs",  3'b100, 24, 10, 1'b1);
        run_sweep("R6 rj24 64fs",  3'b100, 32, 11, 1'b1);
        run_sweep("R9 code 101",   3'b101, 32, 12, 1'b0);
        run_sweep("R9 code 110",   3'b110, 24, 13, 1'b0);
        run_sweep("R8 i2s resume", 3'b011, 32, 14, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule